// File: doc/BRIEF.md
# Flash Status Auto-Poll Engine

This block keeps re-reading a serial flash device's status register until the value read back shows the state software is waiting for, such as a cleared busy bit. Each read is a complete transaction that the phase sequencer builds from the configured command, address, dummy and lane settings. The engine only decides when to ask for another read and when to stop. After each read it compares the assembled status against an expected value under a mask. A match ends the loop, sets a sticky end flag and raises the end interrupt unless that interrupt is masked.

With polling disabled, a start trigger produces exactly one transaction and then ends, as an ordinary transfer does. A stop trigger cancels the loop in any state. Chip-select recovery between reads is enforced by a programmable idle gap. Timeouts are left to software.

The controller is a four-state machine:

- **ST_IDLE**: waits for start.
- **ST_REQ**: asserts `seq_req` for one cycle and clears the status capture.
- **ST_WAIT**: collects status bytes until the sequencer reports done.
- **ST_GAP**: counts the deselect interval.

Its transitions are:

- ST_IDLE to ST_REQ on start.
- ST_REQ to ST_WAIT unconditionally.
- ST_WAIT to ST_IDLE on done when the read matches or polling is off; this is the finish event.
- ST_WAIT to ST_GAP on done with a mismatch while polling.
- ST_GAP to ST_REQ when the gap expires.
- Any state to ST_IDLE on stop.

Top module: `poll_engine`

## Requirements
- R1: After reset `busy`, `seq_req`, `end_flag` and `end_irq` are all 0.
- R2: A start pulse seen in ST_IDLE makes `seq_req` high for exactly one cycle, in the cycle after the start.
- R3: The first status byte of a read fills bits 7:0 and the second fills bits 15:8. The poll matches when (status AND mask) equals (expected AND mask). The comparison is made only when `seq_done` ends the read, so a matching partial value never ends the poll.
- R4: With `stat_wide` = 0 only one byte is compared, and bits 15:8 of the mask and of the expected value have no effect.
- R5: On a match, `end_flag` becomes 1 and `busy` becomes 0 in the next cycle. No further request is issued.
- R6: On a mismatch while `poll_en` = 1, the next `seq_req` is high exactly `desel_cycles`+2 cycles after the cycle in which `seq_done` was high.
- R7: With `poll_en` = 0, one read ends the operation whatever status it returns.
- R8: A stop pulse returns the engine to idle in the next cycle, without setting `end_flag` and without any further request.
- R9: `end_irq` is `end_flag` gated by `end_irq_mask`, where a 1 in the mask disables the interrupt.
- R10: `clr_end` = 1 clears `end_flag` in the next cycle. If a finish and a clear fall in the same cycle, the set wins.
- R11: A start pulse while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | controller clock |
| rst_n | input | 1 | active-low asynchronous reset |
| poll_en | input | 1 | 1: repeat reads until match; 0: single transfer |
| stat_wide | input | 1 | 1: compare 2 status bytes; 0: compare 1 byte |
| exp_val | input | 16 | expected status value |
| stat_mask | input | 16 | compare mask, 1 = bit is compared |
| desel_cycles | input | 4 | idle cycles between reads |
| start | input | 1 | start trigger pulse |
| stop | input | 1 | stop trigger pulse, aborts at once |
| clr_end | input | 1 | write-one-to-clear for the end flag |
| end_irq_mask | input | 1 | 1 disables the end interrupt |
| rx_valid | input | 1 | a status byte is on `rx_byte` |
| rx_byte | input | 8 | status byte from the sequencer |
| seq_done | input | 1 | sequencer finished the current read |
| seq_req | output | 1 | request one status-read transaction |
| busy | output | 1 | engine not idle |
| end_flag | output | 1 | sticky end-of-operation flag |
| end_irq | output | 1 | end interrupt |

## Verification
A corrupted byte index or captured lane makes the engine spin past a matching status or stop on a wrong one. The request count at the first rising edge of `end_flag` then differs from the expected number of reads. A wrong gap count shifts the arrival of the next `seq_req` by at least one cycle, and that is measured on every repeated read. A state machine stuck outside idle after a stop shows up as `busy` still high one cycle later, or as an extra request in the following quiet window.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_GAP  = 2'd3
    } poll_state_e;
endpackage

// File: rtl/poll_capture.sv
// Assembles status bytes of one read and evaluates the masked match.
module poll_capture #(
    parameter int STAT_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              wide,
    input  logic [STAT_W-1:0] exp_val,
    input  logic [STAT_W-1:0] stat_mask,
    output logic              match
);
    localparam int NB = STAT_W / BYTE_W;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic [IW-1:0]     idx;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] lane_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            stat_q <= '0;
        end else if (clear) begin
            idx    <= '0;
            stat_q <= '0;
        end else if (rx_valid) begin
            for (int b = 0; b < NB; b++) begin
                if (idx == IW'(b)) stat_q[b*BYTE_W +: BYTE_W] <= rx_byte;
            end
            if (idx != IW'(NB - 1)) idx <= idx + 1'b1;
        end
    end

    // lane 0 is always compared; upper lanes only in wide mode
    for (genvar g = 0; g < NB; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign lane_en[BYTE_W-1:0] = '1;
        end else begin : g_upper
            assign lane_en[g*BYTE_W +: BYTE_W] = {BYTE_W{wide}};
        end
    end

    assign match = (((stat_q ^ exp_val) & stat_mask & lane_en) == '0);
endmodule

// File: rtl/poll_gap.sv
// Counts the deselect interval while enabled.
module poll_gap #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [GAP_W-1:0] limit,
    output logic             expired
);
    logic [GAP_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == limit);
endmodule

// File: rtl/poll_engine.sv
module poll_engine #(
    parameter int STAT_W = 16,
    parameter int BYTE_W = 8,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_en,
    input  logic              stat_wide,
    input  logic [STAT_W-1:0] exp_val,
    input  logic [STAT_W-1:0] stat_mask,
    input  logic [GAP_W-1:0]  desel_cycles,
    input  logic              start,
    input  logic              stop,
    input  logic              clr_end,
    input  logic              end_irq_mask,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              seq_done,
    output logic              seq_req,
    output logic              busy,
    output logic              end_flag,
    output logic              end_irq
);
    import poll_pkg::*;

    poll_state_e state, nxt;
    logic        match;
    logic        gap_done;
    logic        finish;

    poll_capture #(.STAT_W(STAT_W), .BYTE_W(BYTE_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_REQ),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .wide     (stat_wide),
        .exp_val  (exp_val),
        .stat_mask(stat_mask),
        .match    (match)
    );

    poll_gap #(.GAP_W(GAP_W)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_GAP),
        .limit  (desel_cycles),
        .expired(gap_done)
    );

    assign finish = (state == ST_WAIT) && seq_done && !stop && (!poll_en || match);

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (start) nxt = ST_REQ;
                ST_REQ:  nxt = ST_WAIT;
                ST_WAIT: if (seq_done) nxt = finish ? ST_IDLE : ST_GAP;
                ST_GAP:  if (gap_done) nxt = ST_REQ;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // sticky end flag: set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       end_flag <= 1'b0;
        else if (finish)  end_flag <= 1'b1;
        else if (clr_end) end_flag <= 1'b0;
    end

    // outputs
    always_comb begin
        seq_req = (state == ST_REQ);
        busy    = (state != ST_IDLE);
        end_irq = end_flag && !end_irq_mask;
    end
endmodule

// File: rtl/poll_engine_chk.sv
module poll_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic stop,
    input logic clr_end,
    input logic end_irq_mask,
    input logic seq_done,
    input logic seq_req,
    input logic busy,
    input logic end_flag,
    input logic end_irq
);
    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req |=> !seq_req);

    p_end_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> $past(seq_done));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !seq_req);

    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!busy && !seq_req));

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |-> !end_irq_mask);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_end && !seq_done) |=> !end_flag);
endmodule

bind poll_engine poll_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop        (stop),
    .clr_end     (clr_end),
    .end_irq_mask(end_irq_mask),
    .seq_done    (seq_done),
    .seq_req     (seq_req),
    .busy        (busy),
    .end_flag    (end_flag),
    .end_irq     (end_irq)
);

// File: tb/test_poll_engine.sv
`timescale 1ns/1ps
module test_poll_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_en = 1'b0, stat_wide = 1'b0;
    logic [15:0] exp_val = '0, stat_mask = '0;
    logic [3:0]  desel_cycles = '0;
    logic        start = 1'b0, stop = 1'b0, clr_end = 1'b0, end_irq_mask = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        seq_done = 1'b0;
    logic        seq_req, busy, end_flag, end_irq;

    int n_checks = 0, n_errors = 0;
    int cyc = 0, done_cyc = 0, last_gap = 0, nreq = 0;
    logic [15:0] tb_stat [3];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    poll_engine i_poll_engine (.*);

    typedef struct packed {
        logic [15:0] e;
        logic [15:0] m;
        logic        w;
        logic [15:0] s0;
        logic [15:0] s1;
        logic [15:0] s2;
        logic [1:0]  n;
        logic [3:0]  d;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{16'h0000, 16'h0001, 1'b0, 16'h0003, 16'h0003, 16'h0002, 2'd3, 4'd3},
        '{16'h0040, 16'h00C0, 1'b0, 16'h0040, 16'h0000, 16'h0000, 2'd1, 4'd0},
        '{16'h8001, 16'hFF01, 1'b1, 16'h0001, 16'h8101, 16'h80FF, 2'd3, 4'd5},
        '{16'hAA00, 16'hFF0F, 1'b0, 16'h0005, 16'h00F0, 16'h00F0, 2'd2, 4'd1},
        '{16'h1234, 16'hFFFF, 1'b1, 16'h1234, 16'h0000, 16'h0000, 2'd1, 4'd15}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        int t = 0;
        while (!end_flag && t < 400) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sequencer model: answers each request with one status read
    initial begin
        forever begin
            @(negedge clk);
            if (seq_req) begin
                logic [15:0] v;
                nreq++;
                v = tb_stat[(nreq > 3) ? 2 : nreq - 1];
                if (nreq > 1) last_gap = cyc - done_cyc;
                @(negedge clk);
                rx_valid = 1'b1;
                rx_byte  = v[7:0];
                if (stat_wide) begin
                    @(negedge clk);
                    rx_byte = v[15:8];
                end
                @(negedge clk);
                rx_valid = 1'b0;
                seq_done = 1'b1;
                done_cyc = cyc;
                @(negedge clk);
                seq_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        tb_stat[0] = '0; tb_stat[1] = '0; tb_stat[2] = '0;
        idle(3);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 seq_req", seq_req, 0);
        chk("R1 end_flag", end_flag, 0);
        chk("R1 end_irq", end_irq, 0);
        rst_n = 1'b1;
        idle(2);

        // table of polling scenarios
        poll_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            exp_val = VEC[i].e; stat_mask = VEC[i].m; stat_wide = VEC[i].w;
            desel_cycles = VEC[i].d;
            tb_stat[0] = VEC[i].s0; tb_stat[1] = VEC[i].s1; tb_stat[2] = VEC[i].s2;
            nreq = 0; last_gap = 0;
            @(negedge clk); clr_end = 1'b1;
            @(negedge clk); clr_end = 1'b0;
            pulse_start();
            wait_end();
            // R3 R4: read count at match shows masked compare, lane order, width
            chk($sformatf("R3 R4 reads vec%0d", i), nreq, 32'(VEC[i].n));
            chk($sformatf("R5 end_flag vec%0d", i), end_flag, 1);
            @(negedge clk);
            chk($sformatf("R5 busy vec%0d", i), busy, 0);
            chk($sformatf("R9 end_irq vec%0d", i), end_irq, 1);
            if (VEC[i].n > 1)
                chk($sformatf("R6 gap vec%0d", i), last_gap, 32'(VEC[i].d) + 2);
            idle(12);
            chk($sformatf("R5 no extra req vec%0d", i), nreq, 32'(VEC[i].n));
        end

        // R2: request pulse timing
        @(negedge clk); clr_end = 1'b1;
        @(negedge clk); clr_end = 1'b0;
        exp_val = 16'h0000; stat_mask = 16'h0001; stat_wide = 1'b0; desel_cycles = 4'd2;
        tb_stat[0] = 16'h0; tb_stat[1] = 16'h0; tb_stat[2] = 16'h0;
        nreq = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2 req after start", seq_req, 1);
        @(negedge clk);
        chk("R2 req one cycle", seq_req, 0);
        wait_end();
        idle(4);

        // R9: masked interrupt
        end_irq_mask = 1'b1;
        @(negedge clk);
        chk("R9 masked irq", end_irq, 0);
        chk("R9 flag kept", end_flag, 1);
        end_irq_mask = 1'b0;

        // R10: clear, then set wins over simultaneous clear
        @(negedge clk); clr_end = 1'b1;
        @(negedge clk);
        chk("R10 cleared", end_flag, 0);
        poll_en = 1'b0; nreq = 0;
        pulse_start();
        wait_end();
        chk("R10 set wins", end_flag, 1);
        @(negedge clk);
        chk("R10 cleared after", end_flag, 0);
        clr_end = 1'b0;
        idle(4);

        // R7 + R11: single read ends on mismatch; restart while busy ignored
        tb_stat[0] = 16'h00FF; tb_stat[1] = 16'h00FF; tb_stat[2] = 16'h00FF;
        nreq = 0;
        pulse_start();
        pulse_start();
        wait_end();
        chk("R7 single end", end_flag, 1);
        idle(12);
        chk("R7 R11 one read", nreq, 1);

        // R8: stop aborts an endless poll
        @(negedge clk); clr_end = 1'b1;
        @(negedge clk); clr_end = 1'b0;
        poll_en = 1'b1; nreq = 0;
        pulse_start();
        idle(12);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk("R8 busy after stop", busy, 0);
        begin
            int held;
            held = nreq;
            idle(30);
            chk("R8 no new req", nreq, held);
        end
        chk("R8 no end flag", end_flag, 0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule